// File: doc/BRIEF.md
# Merging Write Buffer

This block sits behind a write-through cache and in front of slower memory. Every word store from the cache goes into a small set of block-sized entries, so the store completes without waiting for memory. A store whose aligned block already has a pending entry that is not being sent is folded into that entry. Its word is overwritten and its word-valid bit is set. A run of sequential stores therefore collects in one entry, not one entry per word.

Entries leave for memory one at a time, oldest first, over a valid/acknowledge port. Each request carries a whole block, plus a mask of the words that hold data. Memory writes only the masked words. A combinational load port lets the load path look up a word in the buffer. It returns the youngest buffered copy of that word, so a load never reads stale memory data.

A draining entry is frozen. Any store to its block opens a new entry. When every entry is in use and the store cannot merge, the store port applies backpressure.

Top module: `merging_write_buffer`

## Requirements
- R1: After reset the buffer is empty: `memReqValid` is 0, `loadHit` is 0 and `storeReady` is 1.
- R2: `storeReady` is 1 when a free entry exists or when the presented store can merge. A store is taken on a clock edge where `storeValid` and `storeReady` are both 1.
- R3: With merging enabled, a store to block `storeAddr[ADDR_W-1:2]` that matches a valid, non-draining entry writes word `storeAddr[1:0]` into that entry. It sets that word's valid bit and takes no new entry.
- R4: Entries drain in allocation order. A request carries the block address in `memReqAddr`, word w in `memReqData[w*DATA_W +: DATA_W]` and the word-valid bits in `memReqMask` (bit w = word w). The mask is never zero. An edge with `memReqValid` and `memReqAck` both high frees the entry.
- R5: The oldest entry starts draining under any one of three conditions: all its words are valid, another entry is waiting behind it, or IDLE_LIMIT edges (default 8) have passed with no store accepted.
- R6: A draining entry takes no merges. A store to its block opens a new entry.
- R7: When all entries are valid and the store cannot merge, `storeReady` is 0 until an entry is freed. Occupancy never exceeds NUM_ENTRIES.
- R8: A load returns `loadHit`=1 and the word when some valid entry holds a valid copy of it. When several entries hold a copy, the youngest copy is returned.
- R9: While `memReqValid` is high and `memReqAck` is low, the request address, mask and data do not change.
- R10: A store and a drain completion on the same edge are both applied.
- R11: With merging disabled (MERGE_EN=0), every store takes its own entry. The first four stores fill the buffer.
- R12: With merging enabled, 16 sequential word stores fill exactly four entries, each with all words valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| storeValid | input | 1 | Store presented |
| storeReady | output | 1 | Store can be accepted this cycle |
| storeAddr | input | ADDR_W | Word address of the store |
| storeData | input | DATA_W | Store data |
| memReqValid | output | 1 | Block write request to memory |
| memReqAck | input | 1 | Memory accepts the request |
| memReqAddr | output | ADDR_W-2 | Block address of the request |
| memReqMask | output | WORDS_PER_BLOCK | Words to write |
| memReqData | output | WORDS_PER_BLOCK*DATA_W | Block data, word w in slice w |
| loadAddr | input | ADDR_W | Word address looked up for forwarding |
| loadHit | output | 1 | Buffered copy found |
| loadData | output | DATA_W | Youngest buffered copy |

## Verification
The hardest situations to reach are those where a draining entry and a younger entry hold the same block. The same applies to a store landing on the same edge as a drain acknowledge. The bench holds the acknowledge low while it fills one block, so that entry starts draining. It then stores to that block again and checks three things: the request stays frozen, forwarding returns the new word, and the second entry drains later with only its own word set. For the same-edge case, the bench fills three entries, then drives a new store together with the acknowledge. Exactly one more store must then be accepted before backpressure appears, and the drain order must include the store that came with the acknowledge.

// File: rtl/mwb_pkg.sv
package mwb_pkg;
  typedef struct packed {
    logic alloc;   // open a new entry at writeIdx
    logic merge;   // fold the store into entry writeIdx
    logic free;    // release the head entry
  } wbStrobes_t;
endpackage

// File: rtl/mwb_datapath.sv
module mwb_datapath
  import mwb_pkg::*;
#(
  parameter int NUM_ENTRIES     = 4,
  parameter int WORDS_PER_BLOCK = 4,
  parameter int ADDR_W          = 16,
  parameter int DATA_W          = 32,
  localparam int OFF_W = $clog2(WORDS_PER_BLOCK),
  localparam int TAG_W = ADDR_W - OFF_W,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [ADDR_W-1:0]                 storeAddr,
  input  logic [DATA_W-1:0]                 storeData,
  input  wbStrobes_t                        strobes,
  input  logic [IDX_W-1:0]                  writeIdx,
  input  logic [IDX_W-1:0]                  headIdx,
  input  logic [ADDR_W-1:0]                 loadAddr,
  output logic [NUM_ENTRIES-1:0]            matchVec,
  output logic [NUM_ENTRIES-1:0]            fullVec,
  output logic [TAG_W-1:0]                  memReqAddr,
  output logic [WORDS_PER_BLOCK-1:0]        memReqMask,
  output logic [WORDS_PER_BLOCK*DATA_W-1:0] memReqData,
  output logic                              loadHit,
  output logic [DATA_W-1:0]                 loadData
);
  logic                       entValid [NUM_ENTRIES];
  logic [WORDS_PER_BLOCK-1:0] wordVal  [NUM_ENTRIES];
  logic [TAG_W-1:0]           tagMem   [NUM_ENTRIES];
  logic [DATA_W-1:0]          dataMem  [NUM_ENTRIES][WORDS_PER_BLOCK];

  logic [TAG_W-1:0]           storeTag, loadTag;
  logic [OFF_W-1:0]           storeOff, loadOff;
  logic [WORDS_PER_BLOCK-1:0] wordSel;

  assign storeTag = storeAddr[ADDR_W-1:OFF_W];
  assign storeOff = storeAddr[OFF_W-1:0];
  assign loadTag  = loadAddr[ADDR_W-1:OFF_W];
  assign loadOff  = loadAddr[OFF_W-1:0];

  always_comb begin
    wordSel = '0;
    wordSel[storeOff] = 1'b1;
  end

  // Valid state: reset, freed at the head, set on allocate or merge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        entValid[e] <= 1'b0;
        wordVal[e]  <= '0;
      end
    end else begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        if (strobes.free && headIdx == IDX_W'(e)) begin
          entValid[e] <= 1'b0;
          wordVal[e]  <= '0;
        end
        if (strobes.alloc && writeIdx == IDX_W'(e)) begin
          entValid[e] <= 1'b1;
          wordVal[e]  <= wordSel;
        end else if (strobes.merge && writeIdx == IDX_W'(e)) begin
          wordVal[e]  <= wordVal[e] | wordSel;
        end
      end
    end
  end

  // Payload storage carries no reset; valid bits qualify it.
  always_ff @(posedge clk) begin
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      if ((strobes.alloc || strobes.merge) && writeIdx == IDX_W'(e))
        dataMem[e][storeOff] <= storeData;
      if (strobes.alloc && writeIdx == IDX_W'(e))
        tagMem[e] <= storeTag;
    end
  end

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_cmp
    assign matchVec[e] = entValid[e] && (tagMem[e] == storeTag);
    assign fullVec[e]  = &wordVal[e];
  end

  // Drain view of the head entry.
  assign memReqAddr = tagMem[headIdx];
  assign memReqMask = wordVal[headIdx];
  always_comb begin
    for (int w = 0; w < WORDS_PER_BLOCK; w++)
      memReqData[w*DATA_W +: DATA_W] = dataMem[headIdx][w];
  end

  // Forwarding: walk from oldest to youngest, later hits override.
  always_comb begin
    logic [IDX_W-1:0] idx;
    loadHit  = 1'b0;
    loadData = '0;
    for (int k = 0; k < NUM_ENTRIES; k++) begin
      idx = IDX_W'((int'(headIdx) + k) % NUM_ENTRIES);
      if (entValid[idx] && tagMem[idx] == loadTag && wordVal[idx][loadOff]) begin
        loadHit  = 1'b1;
        loadData = dataMem[idx][loadOff];
      end
    end
  end
endmodule

// File: rtl/mwb_control.sv
module mwb_control
  import mwb_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int IDLE_LIMIT  = 8,
  parameter bit MERGE_EN    = 1'b1,
  localparam int IDX_W  = $clog2(NUM_ENTRIES),
  localparam int CNT_W  = $clog2(NUM_ENTRIES + 1),
  localparam int IDLE_W = $clog2(IDLE_LIMIT + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   storeValid,
  output logic                   storeReady,
  input  logic [NUM_ENTRIES-1:0] matchVec,
  input  logic [NUM_ENTRIES-1:0] fullVec,
  output logic                   memReqValid,
  input  logic                   memReqAck,
  output wbStrobes_t             strobes,
  output logic [IDX_W-1:0]       writeIdx,
  output logic [IDX_W-1:0]       headIdx,
  output logic [CNT_W-1:0]       occupancy
);
  logic [IDX_W-1:0]       headQ, tailQ, mergeIdx;
  logic [CNT_W-1:0]       countQ;
  logic [IDLE_W-1:0]      idleQ;
  logic                   lockQ;
  logic                   headValid, startCond, canMerge, storeFire;
  logic [NUM_ENTRIES-1:0] headOneHot, mergeVec;

  function automatic logic [IDX_W-1:0] nextPtr(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(NUM_ENTRIES - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    headValid  = (countQ != '0);
    headOneHot = '0;
    headOneHot[headQ] = 1'b1;
    startCond  = headValid && (fullVec[headQ] || countQ > CNT_W'(1) ||
                               idleQ == IDLE_W'(IDLE_LIMIT));
    memReqValid = headValid && (lockQ || startCond);
    if (MERGE_EN)
      mergeVec = matchVec & ~(memReqValid ? headOneHot : '0);
    else
      mergeVec = '0;
    canMerge = |mergeVec;
    mergeIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--)
      if (mergeVec[i]) mergeIdx = IDX_W'(i);
    storeReady = canMerge || (countQ < CNT_W'(NUM_ENTRIES));
    storeFire  = storeValid && storeReady;
    strobes.merge = storeFire && canMerge;
    strobes.alloc = storeFire && !canMerge;
    strobes.free  = memReqValid && memReqAck;
    writeIdx = canMerge ? mergeIdx : tailQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headQ  <= '0;
      tailQ  <= '0;
      countQ <= '0;
      lockQ  <= 1'b0;
      idleQ  <= '0;
    end else begin
      if (strobes.alloc) tailQ <= nextPtr(tailQ);
      if (strobes.free)  headQ <= nextPtr(headQ);
      countQ <= countQ + CNT_W'(strobes.alloc) - CNT_W'(strobes.free);
      lockQ  <= strobes.free ? 1'b0 : memReqValid;
      if (storeFire || !headValid)
        idleQ <= '0;
      else if (idleQ != IDLE_W'(IDLE_LIMIT))
        idleQ <= idleQ + 1'b1;
    end
  end

  assign headIdx   = headQ;
  assign occupancy = countQ;
endmodule

// File: rtl/merging_write_buffer.sv
module merging_write_buffer
  import mwb_pkg::*;
#(
  parameter int NUM_ENTRIES     = 4,
  parameter int WORDS_PER_BLOCK = 4,
  parameter int ADDR_W          = 16,
  parameter int DATA_W          = 32,
  parameter int IDLE_LIMIT      = 8,
  parameter bit MERGE_EN        = 1'b1,
  localparam int OFF_W = $clog2(WORDS_PER_BLOCK),
  localparam int IDX_W = $clog2(NUM_ENTRIES),
  localparam int CNT_W = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              storeValid,
  output logic                              storeReady,
  input  logic [ADDR_W-1:0]                 storeAddr,
  input  logic [DATA_W-1:0]                 storeData,
  output logic                              memReqValid,
  input  logic                              memReqAck,
  output logic [ADDR_W-OFF_W-1:0]           memReqAddr,
  output logic [WORDS_PER_BLOCK-1:0]        memReqMask,
  output logic [WORDS_PER_BLOCK*DATA_W-1:0] memReqData,
  input  logic [ADDR_W-1:0]                 loadAddr,
  output logic                              loadHit,
  output logic [DATA_W-1:0]                 loadData
);
  wbStrobes_t             strobes;
  logic [IDX_W-1:0]       writeIdx, headIdx;
  logic [NUM_ENTRIES-1:0] matchVec, fullVec;
  logic [CNT_W-1:0]       occupancy;

  mwb_control #(
    .NUM_ENTRIES(NUM_ENTRIES), .IDLE_LIMIT(IDLE_LIMIT), .MERGE_EN(MERGE_EN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .storeValid(storeValid), .storeReady(storeReady),
    .matchVec(matchVec), .fullVec(fullVec), .memReqValid(memReqValid),
    .memReqAck(memReqAck), .strobes(strobes), .writeIdx(writeIdx),
    .headIdx(headIdx), .occupancy(occupancy)
  );

  mwb_datapath #(
    .NUM_ENTRIES(NUM_ENTRIES), .WORDS_PER_BLOCK(WORDS_PER_BLOCK),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .storeAddr(storeAddr), .storeData(storeData),
    .strobes(strobes), .writeIdx(writeIdx), .headIdx(headIdx),
    .loadAddr(loadAddr), .matchVec(matchVec), .fullVec(fullVec),
    .memReqAddr(memReqAddr), .memReqMask(memReqMask), .memReqData(memReqData),
    .loadHit(loadHit), .loadData(loadData)
  );
endmodule

// File: rtl/mwb_checker.sv
module mwb_checker #(
  parameter int NUM_ENTRIES = 4,
  parameter int TAG_W       = 14,
  parameter int WPB         = 4,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              storeValid,
  input logic              storeReady,
  input logic              memReqValid,
  input logic              memReqAck,
  input logic [TAG_W-1:0]  memReqAddr,
  input logic [WPB-1:0]    memReqMask,
  input logic [WPB*DATA_W-1:0] memReqData,
  input logic [CNT_W-1:0]  occupancy
);
  a_r1_reset_empty: assert property (@(posedge clk)
    !rstN |=> (!memReqValid && storeReady && occupancy == '0));

  a_r4_mask_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memReqMask != '0);

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqAck) |=> (memReqValid && $stable(memReqAddr) &&
                                     $stable(memReqMask) && $stable(memReqData)));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= CNT_W'(NUM_ENTRIES));

  a_r7_stall_only_full: assert property (@(posedge clk) disable iff (!rstN)
    !storeReady |-> occupancy == CNT_W'(NUM_ENTRIES));

  a_r10_free_drops_count: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqAck && !storeValid) |=>
      (int'(occupancy) == int'($past(occupancy)) - 1));
endmodule

bind merging_write_buffer mwb_checker #(
  .NUM_ENTRIES(NUM_ENTRIES), .TAG_W(ADDR_W - OFF_W), .WPB(WORDS_PER_BLOCK),
  .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .storeValid(storeValid), .storeReady(storeReady),
  .memReqValid(memReqValid), .memReqAck(memReqAck), .memReqAddr(memReqAddr),
  .memReqMask(memReqMask), .memReqData(memReqData), .occupancy(occupancy)
);

// File: tb/tb_merging_write_buffer.sv
`timescale 1ns/1ps
module tb_merging_write_buffer;
  logic        clk = 1'b0;
  logic        rstN;
  logic        storeValid, memAck;
  logic [15:0] storeAddr, loadAddr;
  logic [31:0] storeData;

  logic         storeReady, memReqValid, loadHit;
  logic [13:0]  memReqAddr;
  logic [3:0]   memReqMask;
  logic [127:0] memReqData;
  logic [31:0]  loadData;

  logic         nmReady, nmReqValid, nmHit;
  logic [13:0]  nmReqAddr;
  logic [3:0]   nmReqMask;
  logic [127:0] nmReqData;
  logic [31:0]  nmLoadData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  merging_write_buffer dut (
    .clk(clk), .rstN(rstN), .storeValid(storeValid), .storeReady(storeReady),
    .storeAddr(storeAddr), .storeData(storeData), .memReqValid(memReqValid),
    .memReqAck(memAck), .memReqAddr(memReqAddr), .memReqMask(memReqMask),
    .memReqData(memReqData), .loadAddr(loadAddr), .loadHit(loadHit),
    .loadData(loadData)
  );

  merging_write_buffer #(.MERGE_EN(1'b0)) dutNm (
    .clk(clk), .rstN(rstN), .storeValid(storeValid), .storeReady(nmReady),
    .storeAddr(storeAddr), .storeData(storeData), .memReqValid(nmReqValid),
    .memReqAck(memAck), .memReqAddr(nmReqAddr), .memReqMask(nmReqMask),
    .memReqData(nmReqData), .loadAddr(loadAddr), .loadHit(nmHit),
    .loadData(nmLoadData)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] wa(input int blk, input int w);
    return 16'(blk * 4 + w);
  endfunction

  task automatic doReset;
    rstN = 1'b0; storeValid = 1'b0; memAck = 1'b0;
    storeAddr = '0; storeData = '0; loadAddr = '0;
    repeat (2) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic storeWord(input int blk, input int w, input logic [31:0] d);
    @(negedge clk);
    storeAddr = wa(blk, w); storeData = d; storeValid = 1'b1; #1;
    for (int g = 0; g < 50 && !storeReady; g++) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    storeValid = 1'b0;
  endtask

  task automatic probeReady(input int blk, input int w, input logic exp,
                            input string req);
    @(negedge clk); storeAddr = wa(blk, w); #1;
    chk(req, "storeReady", storeReady, exp);
  endtask

  task automatic drainOne(input int blk, input logic [3:0] mask, input int w,
                          input logic [31:0] d, input string req);
    @(negedge clk); #1;
    for (int g = 0; g < 30 && !memReqValid; g++) begin @(negedge clk); #1; end
    chk(req, "memReqValid", memReqValid, 1'b1);
    chk(req, "memReqAddr", memReqAddr, 14'(blk));
    chk(req, "memReqMask", memReqMask, mask);
    chk(req, "memReqData word", memReqData[w*32 +: 32], d);
    memAck = 1'b1;
    @(posedge clk); #1;
    memAck = 1'b0;
  endtask

  task automatic drainNm(input int blk, input logic [3:0] mask, input int w,
                         input logic [31:0] d, input string req);
    @(negedge clk); #1;
    for (int g = 0; g < 30 && !nmReqValid; g++) begin @(negedge clk); #1; end
    chk(req, "nm memReqValid", nmReqValid, 1'b1);
    chk(req, "nm memReqAddr", nmReqAddr, 14'(blk));
    chk(req, "nm memReqMask", nmReqMask, mask);
    chk(req, "nm memReqData word", nmReqData[w*32 +: 32], d);
    memAck = 1'b1;
    @(posedge clk); #1;
    memAck = 1'b0;
  endtask

  task automatic testReset;   // R1
    doReset();
    @(negedge clk); #1;
    chk("R1", "memReqValid", memReqValid, 1'b0);
    chk("R1", "storeReady", storeReady, 1'b1);
    loadAddr = wa(0, 0); #1;
    chk("R1", "loadHit", loadHit, 1'b0);
  endtask

  task automatic testMerge;   // R3 R4 R5
    doReset();
    for (int w = 0; w < 3; w++) storeWord(5, w, 32'hA0 + w);
    @(negedge clk); #1;
    chk("R5", "no drain while partial and young", memReqValid, 1'b0);
    storeWord(5, 3, 32'hA3);
    @(negedge clk); #1;
    chk("R3", "full entry drains", memReqValid, 1'b1);
    for (int w = 0; w < 3; w++)
      chk("R4", "merged word", memReqData[w*32 +: 32], 32'hA0 + w);
    drainOne(5, 4'hF, 3, 32'hA3, "R3");
    @(negedge clk); #1;
    chk("R4", "freed after ack", memReqValid, 1'b0);
  endtask

  task automatic testIdle;    // R5
    doReset();
    storeWord(9, 2, 32'h99);
    repeat (7) @(posedge clk); #1;
    chk("R5", "before idle limit", memReqValid, 1'b0);
    @(posedge clk); #1;
    chk("R5", "at idle limit", memReqValid, 1'b1);
    chk("R4", "single word mask", memReqMask, 4'b0100);
  endtask

  task automatic testLock;    // R6 R8 R9
    doReset();
    for (int w = 0; w < 4; w++) storeWord(5, w, 32'hA0 + w);
    storeWord(5, 1, 32'h55);
    @(negedge clk); #1;
    chk("R6", "draining mask untouched", memReqMask, 4'hF);
    chk("R9", "draining data untouched", memReqData[32 +: 32], 32'hA1);
    loadAddr = wa(5, 1); #1;
    chk("R8", "youngest hit", loadHit, 1'b1);
    chk("R8", "youngest data", loadData, 32'h55);
    loadAddr = wa(5, 0); #1;
    chk("R8", "older only copy", loadData, 32'hA0);
    drainOne(5, 4'hF, 1, 32'hA1, "R6");
    drainOne(5, 4'b0010, 1, 32'h55, "R6");
  endtask

  task automatic testForward; // R8
    doReset();
    storeWord(3, 2, 32'h11);
    @(negedge clk);
    loadAddr = wa(3, 2); #1;
    chk("R8", "hit", loadHit, 1'b1);
    chk("R8", "data", loadData, 32'h11);
    loadAddr = wa(3, 1); #1;
    chk("R8", "other word miss", loadHit, 1'b0);
    loadAddr = wa(4, 2); #1;
    chk("R8", "other block miss", loadHit, 1'b0);
  endtask

  task automatic testFull;    // R2 R7
    doReset();
    for (int b = 10; b < 14; b++) storeWord(b, 0, 32'h100 + b);
    probeReady(14, 0, 1'b0, "R7");
    probeReady(12, 1, 1'b1, "R2");
    probeReady(10, 1, 1'b0, "R7");
    drainOne(10, 4'b0001, 0, 32'h10A, "R7");
    probeReady(14, 0, 1'b1, "R7");
  endtask

  task automatic testSameEdge; // R10 R4
    doReset();
    for (int b = 20; b < 23; b++) storeWord(b, 0, 32'h200 + b);
    @(negedge clk);
    storeAddr = wa(23, 0); storeData = 32'h217; storeValid = 1'b1; memAck = 1'b1; #1;
    chk("R10", "request present", memReqValid, 1'b1);
    chk("R10", "store ready", storeReady, 1'b1);
    @(posedge clk); #1;
    storeValid = 1'b0; memAck = 1'b0;
    probeReady(24, 0, 1'b1, "R10");
    storeWord(24, 0, 32'h218);
    probeReady(25, 0, 1'b0, "R10");
    for (int b = 21; b < 25; b++) drainOne(b, 4'b0001, 0, 32'h200 + b, "R4");
  endtask

  task automatic testSequential; // R12
    doReset();
    for (int a = 64; a < 80; a++) storeWord(a / 4, a % 4, 32'hC000_0000 + a);
    probeReady(20, 0, 1'b0, "R12");
    for (int e = 0; e < 4; e++)
      drainOne(16 + e, 4'hF, e, 32'hC000_0000 + (16 + e) * 4 + e, "R12");
  endtask

  task automatic testNoMerge; // R11
    doReset();
    for (int w = 0; w < 4; w++) storeWord(16, w, 32'hD0 + w);
    @(negedge clk); storeAddr = wa(16, 0); #1;
    chk("R11", "no-merge buffer full", nmReady, 1'b0);
    chk("R11", "merging buffer has room", storeReady, 1'b1);
    for (int w = 0; w < 4; w++)
      drainNm(16, 4'(1 << w), w, 32'hD0 + w, "R11");
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0;
    testReset();
    testMerge();
    testIdle();
    testLock();
    testForward();
    testFull();
    testSameEdge();
    testSequential();
    testNoMerge();
    finishRun();
  end
endmodule